// File: doc/BRIEF.md
# Extended 64-bit Integer ALU

This block is a purely combinational integer arithmetic and logic unit for a 64-bit core. It takes two 64-bit operands, `srcA` and `srcB`, and a 7-bit operation code, and it returns one 64-bit result. Besides the usual shifts, adds, compares and logic, it runs several fused operations in one pass. These are add after a fixed right shift, add of a single low bit, an add that merges an upper immediate with a sign-extended low immediate, and logic results cut down to one bit or to a zero-extended halfword. The instruction decoder can hand such fused pairs to it as a single micro-op.

The three top bits of the operation code name the group. A small decoder turns the code into a struct of strobes. A datapath module computes every candidate result, and the strobes pick one. Any code that has no operation assigned returns zero.

Top module: `xalu_top`

## Requirements
- R1: The group is `opcode[6:4]`. 000 is shift and bit ops, 001 is 32-bit word ops, 010 is the add family, 011 is subtract and compare, 100 and 101 are logic and byte ops, 110 is narrowed logic and 111 is conditional zero. Every code not listed in R2 to R14 returns zero, for example 0x2E, 0x50, 0x68 to 0x6F, 0x70 and 0x7F.
- R2: The 64-bit shifts take their amount from `srcB[5:0]`. 0x01 is left logical, 0x05 is right logical, 0x07 is right arithmetic, 0x09 is rotate left and 0x0B is rotate right, and both rotates wrap around all 64 bits. 0x00 shifts the zero-extended `srcA[31:0]` left.
- R3: The single-bit ops index one bit with `srcB[5:0]` and ignore `srcB[63:6]`. 0x02 clears that bit of `srcA`, 0x03 sets it, and 0x04 inverts it. 0x06 returns that bit in bit 0 with zeros above.
- R4: The word shifts take their amount from `srcB[4:0]` and work on `srcA[31:0]` only. 0x18 is left, 0x19 is right logical, 0x1A is right arithmetic, 0x1C is rotate left within 32 bits and 0x1D is rotate right within 32 bits. Bit 31 of the 32-bit result is copied into bits 63:32.
- R5: The word arithmetic codes sign-extend bit 31 of their 32-bit result. 0x10 returns A+B, 0x12 returns A−B and 0x11 returns `srcA[0]`+B.
- R6: The narrowed word adds all start from the sum A+B. 0x14 returns sum bit 0 alone, 0x15 returns sum[7:0] zero-extended, 0x16 returns sum[15:0] zero-extended and 0x17 returns sum[15:0] sign-extended.
- R7: 0x21 returns A+B and 0x20 returns zero-extended `srcA[31:0]`+B. 0x22 returns `srcA[0]`+B. The shift-left-and-add codes shift A left before adding B: 0x29, 0x2B, 0x2D and 0x2F shift all of A by 1, 2, 3 and 4. 0x28, 0x2A and 0x2C shift the zero-extended `srcA[31:0]` by 1, 2 and 3.
- R8: Codes 0x24, 0x25, 0x26 and 0x27 shift A right logically by 29, 30, 31 and 32 and then add B.
- R9: 0x23 returns the sign-extended `srcB[11:0]` plus `srcB` with its low 12 bits cleared. 0x13 forms the same sum at 32 bits and sign-extends it to 64 bits.
- R10: 0x30 returns A−B. 0x31 is the unsigned less-than and 0x32 the signed less-than, and both return 1 or 0 in bit 0 with zeros above. 0x34 is unsigned max, 0x35 unsigned min, 0x36 signed max and 0x37 signed min, all over the full 64 bits.
- R11: 0x40 is AND, 0x42 is OR and 0x44 is XOR. 0x41, 0x43 and 0x45 do the same with B inverted first. 0x46 sets each byte of A to 0xFF if that byte is nonzero and to 0x00 if it is zero. 0x51 reverses the byte order of A.
- R12: 0x48 sign-extends `srcA[7:0]` and 0x4A sign-extends `srcA[15:0]`. 0x49 returns {B[7:0],A[7:0]} zero-extended. 0x4B returns {B[15:0],A[15:0]} sign-extended from bit 31. 0x52 returns {B[31:0],A[31:0]}.
- R13: Codes 0x60 to 0x67 pick a logic function with `opcode[2:1]`: 00 is AND, 01 is OR, 10 is XOR and 11 is the byte OR-combine of A. When `opcode[0]` is 0 the code returns only bit 0 of that function's result. When `opcode[0]` is 1 it returns the result's bits [15:0] zero-extended.
- R14: 0x74 returns zero when B is zero and A otherwise. 0x76 returns zero when B is nonzero and A otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 7 | Operation code; bits 6:4 select the group |
| srcA | input | 64 | First operand |
| srcB | input | 64 | Second operand, shift amount or bit index |
| result | output | 64 | Result of the selected operation |

## Verification
The block holds no registers, so every result settles in the same cycle its inputs change, with no cycles of latency. The bench changes opcode and operands one time unit after a rising edge. It compares the output with its behavioural model at the next falling edge, half a period later, so one code is checked per clock. It runs all 128 codes against a set of edge-value operand pairs and random pairs. This also checks that every code not listed returns zero.

// File: rtl/xalu_pkg.sv
package xalu_pkg;

  localparam int OPW = 7;

  typedef enum logic [2:0] {
    RS_SHIFT, RS_BIT, RS_ADD, RS_CMP, RS_LOGIC, RS_BYTE, RS_CZERO, RS_NONE
  } resSelT;

  typedef enum logic [2:0] {
    SH_LL, SH_RL, SH_RA, SH_ROL, SH_ROR
  } shiftOpT;

  typedef enum logic [1:0] {
    BT_CLR, BT_SET, BT_INV, BT_EXT
  } bitOpT;

  typedef enum logic [2:0] {
    AA_FULL, AA_ZEXT, AA_LSB, AA_SHR, AA_SEXT12
  } addASrcT;

  typedef enum logic [2:0] {
    NR_NONE, NR_BIT, NR_BYTE, NR_ZHALF, NR_SHALF
  } addNarrowT;

  typedef enum logic [2:0] {
    CM_SLTU, CM_SLT, CM_MAXU, CM_MINU, CM_MAX, CM_MIN
  } cmpOpT;

  typedef enum logic [1:0] {
    LG_AND, LG_OR, LG_XOR, LG_ORCB
  } logicOpT;

  typedef enum logic [1:0] {
    LN_NONE, LN_LSB, LN_ZHALF
  } logicNarrowT;

  typedef enum logic [2:0] {
    BY_REV8, BY_PACK, BY_PACKH, BY_PACKW, BY_SEXTB, BY_SEXTH
  } byteOpT;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic        legal;
    resSelT      resSel;
    logic        wordRes;     // sign-extend bit 31 of the final result
    shiftOpT     shiftOp;
    logic        shiftZextA;
    bitOpT       bitOp;
    addASrcT     addASrc;
    logic [2:0]  addShl;
    logic [1:0]  addShrSel;
    logic        addMaskB;    // clear low 12 bits of B
    logic        addSub;
    addNarrowT   addNarrow;
    cmpOpT       cmpOp;
    logicOpT     logicOp;
    logic        logicInvB;
    logicNarrowT logicNarrow;
    byteOpT      byteOp;
    logic        czNez;
  } aluCtrlT;

endpackage

// File: rtl/xalu_ctrl.sv
module xalu_ctrl
  import xalu_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  output aluCtrlT        ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.resSel = RS_NONE;
    casez (opcode)
      // group 000: shifts and single-bit ops
      7'b000_0000: begin ctrl.legal = 1'b1; ctrl.resSel = RS_SHIFT; ctrl.shiftOp = SH_LL; ctrl.shiftZextA = 1'b1; end
      7'b000_0001: begin ctrl.legal = 1'b1; ctrl.resSel = RS_SHIFT; ctrl.shiftOp = SH_LL;  end
      7'b000_0101: begin ctrl.legal = 1'b1; ctrl.resSel = RS_SHIFT; ctrl.shiftOp = SH_RL;  end
      7'b000_0111: begin ctrl.legal = 1'b1; ctrl.resSel = RS_SHIFT; ctrl.shiftOp = SH_RA;  end
      7'b000_1001: begin ctrl.legal = 1'b1; ctrl.resSel = RS_SHIFT; ctrl.shiftOp = SH_ROL; end
      7'b000_1011: begin ctrl.legal = 1'b1; ctrl.resSel = RS_SHIFT; ctrl.shiftOp = SH_ROR; end
      7'b000_0010: begin ctrl.legal = 1'b1; ctrl.resSel = RS_BIT; ctrl.bitOp = BT_CLR; end
      7'b000_0011: begin ctrl.legal = 1'b1; ctrl.resSel = RS_BIT; ctrl.bitOp = BT_SET; end
      7'b000_0100: begin ctrl.legal = 1'b1; ctrl.resSel = RS_BIT; ctrl.bitOp = BT_INV; end
      7'b000_0110: begin ctrl.legal = 1'b1; ctrl.resSel = RS_BIT; ctrl.bitOp = BT_EXT; end
      // group 001: word ops
      7'b001_0000: begin ctrl.legal = 1'b1; ctrl.resSel = RS_ADD; ctrl.wordRes = 1'b1; end
      7'b001_0001: begin ctrl.legal = 1'b1; ctrl.resSel = RS_ADD; ctrl.wordRes = 1'b1; ctrl.addASrc = AA_LSB; end
      7'b001_0010: begin ctrl.legal = 1'b1; ctrl.resSel = RS_ADD; ctrl.wordRes = 1'b1; ctrl.addSub = 1'b1; end
      7'b001_0011: begin
        ctrl.legal = 1'b1; ctrl.resSel = RS_ADD; ctrl.wordRes = 1'b1;
        ctrl.addASrc = AA_SEXT12; ctrl.addMaskB = 1'b1;
      end
      7'b001_0100: begin ctrl.legal = 1'b1; ctrl.resSel = RS_ADD; ctrl.addNarrow = NR_BIT;   end
      7'b001_0101: begin ctrl.legal = 1'b1; ctrl.resSel = RS_ADD; ctrl.addNarrow = NR_BYTE;  end
      7'b001_0110: begin ctrl.legal = 1'b1; ctrl.resSel = RS_ADD; ctrl.addNarrow = NR_ZHALF; end
      7'b001_0111: begin ctrl.legal = 1'b1; ctrl.resSel = RS_ADD; ctrl.addNarrow = NR_SHALF; end
      7'b001_1000: begin ctrl.legal = 1'b1; ctrl.resSel = RS_SHIFT; ctrl.wordRes = 1'b1; ctrl.shiftOp = SH_LL;  end
      7'b001_1001: begin ctrl.legal = 1'b1; ctrl.resSel = RS_SHIFT; ctrl.wordRes = 1'b1; ctrl.shiftOp = SH_RL;  end
      7'b001_1010: begin ctrl.legal = 1'b1; ctrl.resSel = RS_SHIFT; ctrl.wordRes = 1'b1; ctrl.shiftOp = SH_RA;  end
      7'b001_1100: begin ctrl.legal = 1'b1; ctrl.resSel = RS_SHIFT; ctrl.wordRes = 1'b1; ctrl.shiftOp = SH_ROL; end
      7'b001_1101: begin ctrl.legal = 1'b1; ctrl.resSel = RS_SHIFT; ctrl.wordRes = 1'b1; ctrl.shiftOp = SH_ROR; end
      // group 010: add family
      7'b010_0000: begin ctrl.legal = 1'b1; ctrl.resSel = RS_ADD; ctrl.addASrc = AA_ZEXT; end
      7'b010_0001: begin ctrl.legal = 1'b1; ctrl.resSel = RS_ADD; end
      7'b010_0010: begin ctrl.legal = 1'b1; ctrl.resSel = RS_ADD; ctrl.addASrc = AA_LSB; end
      7'b010_0011: begin ctrl.legal = 1'b1; ctrl.resSel = RS_ADD; ctrl.addASrc = AA_SEXT12; ctrl.addMaskB = 1'b1; end
      7'b010_01??: begin
        ctrl.legal = 1'b1; ctrl.resSel = RS_ADD; ctrl.addASrc = AA_SHR; ctrl.addShrSel = opcode[1:0];
      end
      7'b010_1000: begin ctrl.legal = 1'b1; ctrl.resSel = RS_ADD; ctrl.addASrc = AA_ZEXT; ctrl.addShl = 3'd1; end
      7'b010_1001: begin ctrl.legal = 1'b1; ctrl.resSel = RS_ADD; ctrl.addShl = 3'd1; end
      7'b010_1010: begin ctrl.legal = 1'b1; ctrl.resSel = RS_ADD; ctrl.addASrc = AA_ZEXT; ctrl.addShl = 3'd2; end
      7'b010_1011: begin ctrl.legal = 1'b1; ctrl.resSel = RS_ADD; ctrl.addShl = 3'd2; end
      7'b010_1100: begin ctrl.legal = 1'b1; ctrl.resSel = RS_ADD; ctrl.addASrc = AA_ZEXT; ctrl.addShl = 3'd3; end
      7'b010_1101: begin ctrl.legal = 1'b1; ctrl.resSel = RS_ADD; ctrl.addShl = 3'd3; end
      7'b010_1111: begin ctrl.legal = 1'b1; ctrl.resSel = RS_ADD; ctrl.addShl = 3'd4; end
      // group 011: subtract and compare
      7'b011_0000: begin ctrl.legal = 1'b1; ctrl.resSel = RS_ADD; ctrl.addSub = 1'b1; end
      7'b011_0001: begin ctrl.legal = 1'b1; ctrl.resSel = RS_CMP; ctrl.cmpOp = CM_SLTU; end
      7'b011_0010: begin ctrl.legal = 1'b1; ctrl.resSel = RS_CMP; ctrl.cmpOp = CM_SLT;  end
      7'b011_0100: begin ctrl.legal = 1'b1; ctrl.resSel = RS_CMP; ctrl.cmpOp = CM_MAXU; end
      7'b011_0101: begin ctrl.legal = 1'b1; ctrl.resSel = RS_CMP; ctrl.cmpOp = CM_MINU; end
      7'b011_0110: begin ctrl.legal = 1'b1; ctrl.resSel = RS_CMP; ctrl.cmpOp = CM_MAX;  end
      7'b011_0111: begin ctrl.legal = 1'b1; ctrl.resSel = RS_CMP; ctrl.cmpOp = CM_MIN;  end
      // groups 100/101: logic and byte ops
      7'b100_0000: begin ctrl.legal = 1'b1; ctrl.resSel = RS_LOGIC; ctrl.logicOp = LG_AND; end
      7'b100_0001: begin ctrl.legal = 1'b1; ctrl.resSel = RS_LOGIC; ctrl.logicOp = LG_AND; ctrl.logicInvB = 1'b1; end
      7'b100_0010: begin ctrl.legal = 1'b1; ctrl.resSel = RS_LOGIC; ctrl.logicOp = LG_OR;  end
      7'b100_0011: begin ctrl.legal = 1'b1; ctrl.resSel = RS_LOGIC; ctrl.logicOp = LG_OR;  ctrl.logicInvB = 1'b1; end
      7'b100_0100: begin ctrl.legal = 1'b1; ctrl.resSel = RS_LOGIC; ctrl.logicOp = LG_XOR; end
      7'b100_0101: begin ctrl.legal = 1'b1; ctrl.resSel = RS_LOGIC; ctrl.logicOp = LG_XOR; ctrl.logicInvB = 1'b1; end
      7'b100_0110: begin ctrl.legal = 1'b1; ctrl.resSel = RS_LOGIC; ctrl.logicOp = LG_ORCB; end
      7'b100_1000: begin ctrl.legal = 1'b1; ctrl.resSel = RS_BYTE; ctrl.byteOp = BY_SEXTB; end
      7'b100_1001: begin ctrl.legal = 1'b1; ctrl.resSel = RS_BYTE; ctrl.byteOp = BY_PACKH; end
      7'b100_1010: begin ctrl.legal = 1'b1; ctrl.resSel = RS_BYTE; ctrl.byteOp = BY_SEXTH; end
      7'b100_1011: begin ctrl.legal = 1'b1; ctrl.resSel = RS_BYTE; ctrl.byteOp = BY_PACKW; ctrl.wordRes = 1'b1; end
      7'b101_0001: begin ctrl.legal = 1'b1; ctrl.resSel = RS_BYTE; ctrl.byteOp = BY_REV8; end
      7'b101_0010: begin ctrl.legal = 1'b1; ctrl.resSel = RS_BYTE; ctrl.byteOp = BY_PACK; end
      // group 110: narrowed logic, function in bits 2:1, width in bit 0
      7'b110_0???: begin
        ctrl.legal = 1'b1; ctrl.resSel = RS_LOGIC;
        ctrl.logicOp = logicOpT'(opcode[2:1]);
        ctrl.logicNarrow = opcode[0] ? LN_ZHALF : LN_LSB;
      end
      // group 111: conditional zero
      7'b111_0100: begin ctrl.legal = 1'b1; ctrl.resSel = RS_CZERO; end
      7'b111_0110: begin ctrl.legal = 1'b1; ctrl.resSel = RS_CZERO; ctrl.czNez = 1'b1; end
      default: ctrl.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/xalu_shifter.sv
module xalu_shifter
  import xalu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]         src,
  input  logic [$clog2(XLEN)-1:0] amt,
  input  shiftOpT                 op,
  input  logic                    wordMode,
  output logic [XLEN-1:0]         out
);

  localparam int HALF = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);

  logic [HALF-1:0] lo;
  logic [SHW-2:0]  amtW;
  logic [XLEN-1:0] fullRes;
  logic [HALF-1:0] halfRes;

  assign lo   = src[HALF-1:0];
  assign amtW = amt[SHW-2:0];

  always_comb begin
    case (op)
      SH_RL: begin
        fullRes = src >> amt;
        halfRes = lo >> amtW;
      end
      SH_RA: begin
        fullRes = XLEN'($signed(src) >>> amt);
        halfRes = HALF'($signed(lo) >>> amtW);
      end
      SH_ROL: begin
        fullRes = (src << amt) | (src >> (XLEN - int'(amt)));
        halfRes = (lo << amtW) | (lo >> (HALF - int'(amtW)));
      end
      SH_ROR: begin
        fullRes = (src >> amt) | (src << (XLEN - int'(amt)));
        halfRes = (lo >> amtW) | (lo << (HALF - int'(amtW)));
      end
      default: begin
        fullRes = src << amt;
        halfRes = lo << amtW;
      end
    endcase
    out = wordMode ? {{HALF{1'b0}}, halfRes} : fullRes;
  end

  // A rotate moves bits, it never creates or drops one
  always_comb begin
    if ((op == SH_ROL || op == SH_ROR) && !wordMode) begin
      AST_ROT_KEEPS_ONES: assert ($countones(out) == $countones(src)) else $error("64-bit rotate changed popcount"); // R2
    end
    if ((op == SH_ROL || op == SH_ROR) && wordMode) begin
      AST_ROTW_KEEPS_ONES: assert ($countones(out[HALF-1:0]) == $countones(lo)) else $error("word rotate changed popcount"); // R4
    end
  end

endmodule

// File: rtl/xalu_datapath.sv
module xalu_datapath
  import xalu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  aluCtrlT         ctrl,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  output logic [XLEN-1:0] result
);

  localparam int HALF     = XLEN / 2;
  localparam int QUART    = XLEN / 4;
  localparam int SHW      = $clog2(XLEN);
  localparam int NBYTE    = XLEN / 8;
  localparam int IMM_BITS = 12;
  localparam int SHR_BASE = 29;

  // ---------------- shifter ----------------
  logic [XLEN-1:0] shiftSrc, shiftOut;
  assign shiftSrc = ctrl.shiftZextA ? {{HALF{1'b0}}, srcA[HALF-1:0]} : srcA;

  xalu_shifter #(.XLEN(XLEN)) u_shifter (
    .src     (shiftSrc),
    .amt     (srcB[SHW-1:0]),
    .op      (ctrl.shiftOp),
    .wordMode(ctrl.wordRes),
    .out     (shiftOut)
  );

  // ---------------- single-bit ops ----------------
  logic [XLEN-1:0] bitMask, bitOut;
  assign bitMask = {{(XLEN-1){1'b0}}, 1'b1} << srcB[SHW-1:0];

  always_comb begin
    case (ctrl.bitOp)
      BT_CLR:  bitOut = srcA & ~bitMask;
      BT_SET:  bitOut = srcA | bitMask;
      BT_INV:  bitOut = srcA ^ bitMask;
      default: bitOut = {{(XLEN-1){1'b0}}, |(srcA & bitMask)};
    endcase
  end

  // ---------------- adder ----------------
  logic [XLEN-1:0] addBase, addOpA, addOpB, addSum, addOut;

  always_comb begin
    case (ctrl.addASrc)
      AA_ZEXT:   addBase = {{HALF{1'b0}}, srcA[HALF-1:0]};
      AA_LSB:    addBase = {{(XLEN-1){1'b0}}, srcA[0]};
      AA_SHR:    addBase = srcA >> (SHR_BASE + int'(ctrl.addShrSel));
      AA_SEXT12: addBase = {{(XLEN-IMM_BITS){srcB[IMM_BITS-1]}}, srcB[IMM_BITS-1:0]};
      default:   addBase = srcA;
    endcase
    addOpA = addBase << ctrl.addShl;
    addOpB = ctrl.addMaskB ? {srcB[XLEN-1:IMM_BITS], {IMM_BITS{1'b0}}} : srcB;
    addSum = ctrl.addSub ? (addOpA - addOpB) : (addOpA + addOpB);
    case (ctrl.addNarrow)
      NR_BIT:   addOut = {{(XLEN-1){1'b0}}, addSum[0]};
      NR_BYTE:  addOut = {{(XLEN-8){1'b0}}, addSum[7:0]};
      NR_ZHALF: addOut = {{(XLEN-16){1'b0}}, addSum[15:0]};
      NR_SHALF: addOut = {{(XLEN-16){addSum[15]}}, addSum[15:0]};
      default:  addOut = addSum;
    endcase
  end

  // ---------------- compare ----------------
  logic            ltU, ltS;
  logic [XLEN-1:0] cmpOut;
  assign ltU = srcA < srcB;
  assign ltS = $signed(srcA) < $signed(srcB);

  always_comb begin
    case (ctrl.cmpOp)
      CM_SLTU: cmpOut = {{(XLEN-1){1'b0}}, ltU};
      CM_SLT:  cmpOut = {{(XLEN-1){1'b0}}, ltS};
      CM_MAXU: cmpOut = ltU ? srcB : srcA;
      CM_MINU: cmpOut = ltU ? srcA : srcB;
      CM_MAX:  cmpOut = ltS ? srcB : srcA;
      default: cmpOut = ltS ? srcA : srcB;
    endcase
  end

  // ---------------- logic and byte ops ----------------
  logic [XLEN-1:0] orcbA, revA, logicB, logicRaw, logicOut, byteOut;

  for (genvar gi = 0; gi < NBYTE; gi++) begin : g_bytes
    assign orcbA[8*gi +: 8] = {8{|srcA[8*gi +: 8]}};
    assign revA[8*gi +: 8]  = srcA[8*(NBYTE-1-gi) +: 8];
  end

  always_comb begin
    logicB = ctrl.logicInvB ? ~srcB : srcB;
    case (ctrl.logicOp)
      LG_AND:  logicRaw = srcA & logicB;
      LG_OR:   logicRaw = srcA | logicB;
      LG_XOR:  logicRaw = srcA ^ logicB;
      default: logicRaw = orcbA;
    endcase
    case (ctrl.logicNarrow)
      LN_LSB:   logicOut = {{(XLEN-1){1'b0}}, logicRaw[0]};
      LN_ZHALF: logicOut = {{(XLEN-16){1'b0}}, logicRaw[15:0]};
      default:  logicOut = logicRaw;
    endcase
  end

  always_comb begin
    case (ctrl.byteOp)
      BY_REV8:  byteOut = revA;
      BY_PACK:  byteOut = {srcB[HALF-1:0], srcA[HALF-1:0]};
      BY_PACKH: byteOut = {{(XLEN-16){1'b0}}, srcB[7:0], srcA[7:0]};
      BY_PACKW: byteOut = {{HALF{1'b0}}, srcB[QUART-1:0], srcA[QUART-1:0]};
      BY_SEXTB: byteOut = {{(XLEN-8){srcA[7]}}, srcA[7:0]};
      default:  byteOut = {{(XLEN-16){srcA[15]}}, srcA[15:0]};
    endcase
  end

  // ---------------- conditional zero ----------------
  logic            bIsZero;
  logic [XLEN-1:0] czOut;
  assign bIsZero = (srcB == '0);
  assign czOut   = (ctrl.czNez ? !bIsZero : bIsZero) ? '0 : srcA;

  // ---------------- result select ----------------
  logic [XLEN-1:0] selOut;

  always_comb begin
    case (ctrl.resSel)
      RS_SHIFT: selOut = shiftOut;
      RS_BIT:   selOut = bitOut;
      RS_ADD:   selOut = addOut;
      RS_CMP:   selOut = cmpOut;
      RS_LOGIC: selOut = logicOut;
      RS_BYTE:  selOut = byteOut;
      RS_CZERO: selOut = czOut;
      default:  selOut = '0;
    endcase
    if (!ctrl.legal)
      result = '0;
    else if (ctrl.wordRes)
      result = {{HALF{selOut[HALF-1]}}, selOut[HALF-1:0]};
    else
      result = selOut;
  end

  always_comb begin
    if (ctrl.legal && ctrl.resSel == RS_BIT && ctrl.bitOp == BT_EXT) begin
      AST_BIT_EXTRACT_FLAG: assert (result[XLEN-1:1] == '0) else $error("bit extract left upper bits set"); // R3
    end
  end

endmodule

// File: rtl/xalu_top.sv
module xalu_top
  import xalu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OPW-1:0]  opcode,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  output logic [XLEN-1:0] result
);

  localparam int HALF = XLEN / 2;

  aluCtrlT ctrl;

  xalu_ctrl u_ctrl (
    .opcode(opcode),
    .ctrl  (ctrl)
  );

  xalu_datapath #(.XLEN(XLEN)) u_datapath (
    .ctrl  (ctrl),
    .srcA  (srcA),
    .srcB  (srcB),
    .result(result)
  );

  always_comb begin
    if (opcode == 7'b010_1110 || opcode[6:3] == 4'b1101) begin
      AST_UNDEF_ZERO: assert (result == '0) else $error("unassigned code gave nonzero result"); // R1
    end
    if (opcode[6:4] == 3'b001 && opcode[3:2] != 2'b01) begin
      AST_WORD_SEXT: assert (result[XLEN-1:HALF] == {HALF{result[HALF-1]}}) else $error("word result not sign-extended"); // R5
    end
    if (opcode == 7'b011_0001 || opcode == 7'b011_0010) begin
      AST_CMP_FLAG: assert (result[XLEN-1:1] == '0) else $error("set-less-than upper bits set"); // R10
    end
    if (opcode[6:3] == 4'b1100) begin
      AST_NARROW_LOGIC: assert (opcode[0] ? (result[XLEN-1:16] == '0) : (result[XLEN-1:1] == '0)) else $error("narrowed logic too wide"); // R13
    end
    if (opcode == 7'b111_0100 || opcode == 7'b111_0110) begin
      AST_CZERO_CHOICE: assert (result == '0 || result == srcA) else $error("conditional zero gave a third value"); // R14
    end
  end

endmodule

// File: tb/xalu_top_tb.sv
module xalu_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  opcode = '0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  xalu_top u_dut (
    .opcode(opcode),
    .srcA  (srcA),
    .srcB  (srcB),
    .result(result)
  );

  function automatic logic [63:0] sx32(input logic [63:0] x);
    return {{32{x[31]}}, x[31:0]};
  endfunction

  function automatic logic [63:0] rotl(input logic [63:0] x, input int n, input int w);
    logic [63:0] r = x;
    for (int i = 0; i < n; i++) begin
      if (w == 64) r = {r[62:0], r[63]};
      else         r = {32'b0, r[30:0], r[31]};
    end
    return r;
  endfunction

  function automatic logic [63:0] orcombine(input logic [63:0] x);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) if (x[8*i +: 8] != 8'h00) r[8*i +: 8] = 8'hFF;
    return r;
  endfunction

  function automatic logic [63:0] byteswap(input logic [63:0] x);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = x[8*(7-i) +: 8];
    return r;
  endfunction

  // Behavioural reference: result and the requirement it belongs to
  function automatic logic [63:0] refModel(input logic [6:0] op, input logic [63:0] a,
                                           input logic [63:0] b, output string req);
    logic [63:0] s   = a + b;
    logic [63:0] za  = {32'b0, a[31:0]};
    logic [63:0] lui = {{52{b[11]}}, b[11:0]} + {b[63:12], 12'b0};
    int          n6  = int'(b[5:0]);
    int          n5  = int'(b[4:0]);
    logic [63:0] g;
    req = "R1";
    case (op)
      7'h00: begin req = "R2"; return za << n6; end
      7'h01: begin req = "R2"; return a << n6; end
      7'h05: begin req = "R2"; return a >> n6; end
      7'h07: begin req = "R2"; return $signed(a) >>> n6; end
      7'h09: begin req = "R2"; return rotl(a, n6, 64); end
      7'h0B: begin req = "R2"; return rotl(a, (64 - n6) % 64, 64); end
      7'h02: begin req = "R3"; return a & ~(64'd1 << n6); end
      7'h03: begin req = "R3"; return a | (64'd1 << n6); end
      7'h04: begin req = "R3"; return a ^ (64'd1 << n6); end
      7'h06: begin req = "R3"; return {63'b0, a[n6]}; end
      7'h10: begin req = "R5"; return sx32(s); end
      7'h11: begin req = "R5"; return sx32({63'b0, a[0]} + b); end
      7'h12: begin req = "R5"; return sx32(a - b); end
      7'h13: begin req = "R9"; return sx32(lui); end
      7'h14: begin req = "R6"; return {63'b0, s[0]}; end
      7'h15: begin req = "R6"; return {56'b0, s[7:0]}; end
      7'h16: begin req = "R6"; return {48'b0, s[15:0]}; end
      7'h17: begin req = "R6"; return {{48{s[15]}}, s[15:0]}; end
      7'h18: begin req = "R4"; return sx32(za << n5); end
      7'h19: begin req = "R4"; return sx32(za >> n5); end
      7'h1A: begin req = "R4"; g = {{32{a[31]}}, a[31:0]}; return sx32(g >> n5); end
      7'h1C: begin req = "R4"; return sx32(rotl(za, n5, 32)); end
      7'h1D: begin req = "R4"; return sx32(rotl(za, (32 - n5) % 32, 32)); end
      7'h20: begin req = "R7"; return za + b; end
      7'h21: begin req = "R7"; return s; end
      7'h22: begin req = "R7"; return {63'b0, a[0]} + b; end
      7'h23: begin req = "R9"; return lui; end
      7'h24, 7'h25, 7'h26, 7'h27: begin req = "R8"; return (a >> (29 + int'(op[1:0]))) + b; end
      7'h28: begin req = "R7"; return (za << 1) + b; end
      7'h29: begin req = "R7"; return (a << 1) + b; end
      7'h2A: begin req = "R7"; return (za << 2) + b; end
      7'h2B: begin req = "R7"; return (a << 2) + b; end
      7'h2C: begin req = "R7"; return (za << 3) + b; end
      7'h2D: begin req = "R7"; return (a << 3) + b; end
      7'h2F: begin req = "R7"; return (a << 4) + b; end
      7'h30: begin req = "R10"; return a - b; end
      7'h31: begin req = "R10"; return (a < b) ? 64'd1 : 64'd0; end
      7'h32: begin req = "R10"; return ($signed(a) < $signed(b)) ? 64'd1 : 64'd0; end
      7'h34: begin req = "R10"; return (a > b) ? a : b; end
      7'h35: begin req = "R10"; return (a < b) ? a : b; end
      7'h36: begin req = "R10"; return ($signed(a) > $signed(b)) ? a : b; end
      7'h37: begin req = "R10"; return ($signed(a) < $signed(b)) ? a : b; end
      7'h40: begin req = "R11"; return a & b; end
      7'h41: begin req = "R11"; return a & ~b; end
      7'h42: begin req = "R11"; return a | b; end
      7'h43: begin req = "R11"; return a | ~b; end
      7'h44: begin req = "R11"; return a ^ b; end
      7'h45: begin req = "R11"; return ~(a ^ b); end
      7'h46: begin req = "R11"; return orcombine(a); end
      7'h51: begin req = "R11"; return byteswap(a); end
      7'h48: begin req = "R12"; return {{56{a[7]}}, a[7:0]}; end
      7'h49: begin req = "R12"; return {48'b0, b[7:0], a[7:0]}; end
      7'h4A: begin req = "R12"; return {{48{a[15]}}, a[15:0]}; end
      7'h4B: begin req = "R12"; return sx32({32'b0, b[15:0], a[15:0]}); end
      7'h52: begin req = "R12"; return {b[31:0], a[31:0]}; end
      7'h60, 7'h61, 7'h62, 7'h63, 7'h64, 7'h65, 7'h66, 7'h67: begin
        req = "R13";
        case (op[2:1])
          2'b00:   g = a & b;
          2'b01:   g = a | b;
          2'b10:   g = a ^ b;
          default: g = orcombine(a);
        endcase
        return op[0] ? {48'b0, g[15:0]} : {63'b0, g[0]};
      end
      7'h74: begin req = "R14"; return (b == 0) ? 64'd0 : a; end
      7'h76: begin req = "R14"; return (b != 0) ? 64'd0 : a; end
      default: return 64'd0;
    endcase
  endfunction

  task automatic runOne(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] exp;
    string       req;
    @(posedge clk);
    #1;
    opcode = op;
    srcA   = a;
    srcB   = b;
    @(negedge clk);
    exp = refModel(op, a, b, req);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", req, op, a, b, result, exp);
    end
  endtask

  function automatic void pickPair(input int k, output logic [63:0] a, output logic [63:0] b);
    case (k)
      0: begin a = 64'h0;                   b = 64'h0;                   end
      1: begin a = '1;                      b = '1;                      end
      2: begin a = 64'h8000_0000_0000_0001; b = 64'h1;                   end
      3: begin a = 64'h0000_0000_8000_00F0; b = 64'd32;                  end
      4: begin a = 64'h1234_5678_9ABC_DEF0; b = 64'hFFFF_FFFF_FFFF_F800; end
      5: begin a = 64'h0000_00FF_0000_0100; b = 64'h0000_0000_0000_07FF; end
      6: begin a = 64'hF00D_0000_7FFF_FF81; b = 64'hFFFF_FFFF_0000_0041; end
      7: begin a = 64'h7FFF_FFFF_FFFF_FFFF; b = 64'h8000_0000_0000_0000; end
      default: begin a = {$urandom(), $urandom()}; b = {$urandom(), $urandom()}; end
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Idle state with zero inputs: code 0x00 on zero operand gives zero (R2)
    checks++;
    if (result !== 64'd0) begin
      errors++;
      $display("FAIL R2 idle actual=%h expected=%h", result, 64'd0);
    end
    rstN = 1'b1;
    for (int k = 0; k < 14; k++) begin
      for (int op = 0; op < 128; op++) begin
        pickPair(k, a, b);
        runOne(7'(op), a, b);
      end
    end
    // Bit index ignores srcB[63:6]: index 0x41 acts as bit 1 (R3)
    runOne(7'h03, 64'h0, 64'hFFFF_FFFF_FFFF_FFC1);
    // Conditional zero with B exactly zero and A nonzero (R14)
    runOne(7'h74, 64'hDEAD_BEEF_0000_0001, 64'h0);
    runOne(7'h76, 64'hDEAD_BEEF_0000_0001, 64'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule